// File: doc/BRIEF.md
# Two-Wire Bus Condition Control Register

This block is the condition-control register of a two-wire serial bus port. A CPU writes it and reads it over a plain register strobe interface. Through it, software produces bus start and stop conditions by driving the serial-data output latch. It also asks for a software acknowledge, which holds SDA low through the next clock pulse. Two sticky flags report start and stop conditions seen on the bus, and two plain control bits are passed on to the rest of the port.

The SCL and SDA inputs pass through a synchronizer before any edge is examined. A start condition is SDA falling while SCL stays high. A stop condition is SDA rising while SCL stays high. Each sticky flag has its own set of clear events, and a clear event always beats a set event that arrives in the same cycle. Command bits act as one-shot pulses, take effect only while the interface is enabled, and always read as zero.

Register layout, bit 0 first: stop command, start command, stop detected, start detected, ack trigger, ack enable, ack detected, busy enable.

Top module: `twb_cond_ctrl`

## Requirements
- R1: After a synchronous reset, `rd_data` reads 00H (with `ack_det_i` low), `sda_latch` is 1 and `ack_drive` is 0.
- R2: With `if_en` high, a write with bit 0 set drives `sda_latch` to 1 from the next cycle. Bit 0 always reads 0.
- R3: With `if_en` high, a write with bit 1 set and bit 0 clear drives `sda_latch` to 0 from the next cycle. If both bits are set, `sda_latch` becomes 1. Bit 1 always reads 0.
- R4: While `if_en` is low, writes to bits 0, 1 and 4 change neither `sda_latch` nor `ack_drive`.
- R5: An SDA fall while SCL is high sets bit 3 (start detected) no later than the third rising clock edge after the change. The bit then stays set until a clear event.
- R6: An SDA rise while SCL is high sets bit 2 (stop detected) no later than the third rising clock edge after the change. The bit then stays set until a clear event.
- R7: Bit 2 is cleared by `xfer_start`, by `addr_mismatch` or by `if_en` low.
- R8: Bit 3 is cleared by `xfer_start`, by a detected stop condition or by `if_en` low. `addr_mismatch` leaves bit 3 unchanged.
- R9: When a clear event for a flag is registered in the same cycle as a set event for that flag, the flag ends cleared.
- R10: With `if_en` high, writing bit 4 raises `ack_drive` from the next cycle. `ack_drive` stays high until a synchronized SCL falling edge, `xfer_start` or `if_en` low. Bit 4 always reads 0.
- R11: Bits 5 and 7 are plain read/write bits, mirrored on `ack_en` and `busy_en`. Bit 6 reflects `ack_det_i`. Writes to bits 2, 3 and 6 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| if_en | input | 1 | Interface enable; low clears all state bits |
| xfer_start | input | 1 | Transfer-start pulse |
| addr_mismatch | input | 1 | Address-mismatch pulse from the address comparator |
| ack_det_i | input | 1 | Acknowledge-detected status from the shift logic |
| scl_in | input | 1 | Sampled SCL line (asynchronous) |
| sda_in | input | 1 | Sampled SDA line (asynchronous) |
| sda_latch | output | 1 | Serial-data output latch |
| ack_drive | output | 1 | Request to hold SDA low for a software acknowledge |
| ack_en | output | 1 | Acknowledge-enable control bit |
| busy_en | output | 1 | Busy-enable control bit |

## Verification
The hardest case to reach is a clear event registered in exactly the cycle in which a synchronized bus condition sets a flag. The condition takes effect three rising edges after the line moves, so the only way to reach that cycle from the ports is careful counting. The bench changes SDA at a falling clock edge, counts two rising edges, and then pulses `xfer_start` or `addr_mismatch` for one cycle, so the clear lands on the third edge. Random sequences of line moves, writes, pulses and enable toggles cover the remaining orderings of set and clear events.

// File: rtl/twb_pkg.sv
// Package: shared bit positions and widths for the two-wire condition register.
// Assumes an 8-bit register; positions are fixed because software decodes them.
package twb_pkg;
    localparam int REG_W       = 8;
    localparam int B_STOP_CMD  = 0;
    localparam int B_START_CMD = 1;
    localparam int B_STOP_DET  = 2;
    localparam int B_START_DET = 3;
    localparam int B_ACK_TRIG  = 4;
    localparam int B_ACK_EN    = 5;
    localparam int B_ACK_DET   = 6;
    localparam int B_BUSY_EN   = 7;

    // One-cycle bus events produced by the condition detector.
    typedef struct packed {
        logic start_c;
        logic stop_c;
        logic scl_fall;
    } bus_evt_t;
endpackage

// File: rtl/twb_sync.sv
// Module: multi-stage synchronizer for asynchronous line inputs.
// Assumes inputs are quasi-static relative to clk; resets to RST_VAL (idle bus high).
module twb_sync #(
    parameter int WIDTH   = 2,
    parameter int STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift one synchronizer stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[s] <= {WIDTH{RST_VAL}};
                else if (s == 0)
                    stage_q[s] <= d_in;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/twb_cond_detect.sv
// Module: start/stop/SCL-fall detector on synchronized bus lines.
// Assumes scl_s/sda_s are already synchronized; emits single-cycle events.
module twb_cond_detect
    import twb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_s,
    input  logic     sda_s,
    output bus_evt_t evt
);
    logic scl_d, sda_d;

    // Keep the previous synchronized line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Decode bus conditions from level pairs.
    always_comb begin
        evt.start_c  = scl_s && scl_d && sda_d && !sda_s;
        evt.stop_c   = scl_s && scl_d && !sda_d && sda_s;
        evt.scl_fall = scl_d && !scl_s;
    end

    // R5/R6: start and stop cannot be reported together.
    a_r5_evt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(evt.start_c && evt.stop_c));
endmodule

// File: rtl/twb_cond_flags.sv
// Module: sticky detection flags, command pulses, ack request and data latch.
// Assumes command bits are write-one pulses; every clear event beats a set event.
module twb_cond_flags
    import twb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     if_en,
    input  logic     wr_en,
    input  logic     stop_cmd,
    input  logic     start_cmd,
    input  logic     ack_trig,
    input  logic     ack_en_wr,
    input  logic     busy_en_wr,
    input  logic     xfer_start,
    input  logic     addr_mismatch,
    input  bus_evt_t evt,
    output logic     stop_det,
    output logic     start_det,
    output logic     ack_pend,
    output logic     sda_latch,
    output logic     ack_en,
    output logic     busy_en
);
    logic stop_clr, start_clr, ack_clr, cmd_ok;

    // Collect clear conditions for each state bit.
    always_comb begin
        cmd_ok    = wr_en && if_en;
        stop_clr  = !if_en || xfer_start || addr_mismatch;
        start_clr = !if_en || xfer_start || evt.stop_c;
        ack_clr   = !if_en || xfer_start || evt.scl_fall;
    end

    // Stop-detected flag: clear wins over set.
    always_ff @(posedge clk) begin
        if (!rst_n)             stop_det <= 1'b0;
        else if (stop_clr)      stop_det <= 1'b0;
        else if (evt.stop_c)    stop_det <= 1'b1;
    end

    // Start-detected flag: clear wins over set.
    always_ff @(posedge clk) begin
        if (!rst_n)             start_det <= 1'b0;
        else if (start_clr)     start_det <= 1'b0;
        else if (evt.start_c)   start_det <= 1'b1;
    end

    // Software acknowledge request held until the next SCL fall.
    always_ff @(posedge clk) begin
        if (!rst_n)                   ack_pend <= 1'b0;
        else if (ack_clr)             ack_pend <= 1'b0;
        else if (cmd_ok && ack_trig)  ack_pend <= 1'b1;
    end

    // Serial-data output latch driven by the condition commands.
    always_ff @(posedge clk) begin
        if (!rst_n)                    sda_latch <= 1'b1;
        else if (cmd_ok && stop_cmd)   sda_latch <= 1'b1;
        else if (cmd_ok && start_cmd)  sda_latch <= 1'b0;
    end

    // Plain read/write control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_en  <= 1'b0;
            busy_en <= 1'b0;
        end else if (wr_en) begin
            ack_en  <= ack_en_wr;
            busy_en <= busy_en_wr;
        end
    end

    a_r2_stop_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && if_en && stop_cmd) |=> sda_latch);
    a_r3_start_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && if_en && start_cmd && !stop_cmd) |=> !sda_latch);
    a_r4_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && if_en) |=> $stable(sda_latch));
    a_r7_stop_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!if_en || xfer_start || addr_mismatch) |=> !stop_det);
    a_r8_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!if_en || xfer_start || evt.stop_c) |=> !start_det);
    a_r10_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!if_en || xfer_start || evt.scl_fall) |=> !ack_pend);
    a_r6_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && if_en && !xfer_start && !addr_mismatch) |=> stop_det);
endmodule

// File: rtl/twb_cond_ctrl.sv
// Module: top of the two-wire bus condition control register.
// Assumes a single clock domain for the CPU side; bus lines are asynchronous.
module twb_cond_ctrl
    import twb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             if_en,
    input  logic             xfer_start,
    input  logic             addr_mismatch,
    input  logic             ack_det_i,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_latch,
    output logic             ack_drive,
    output logic             ack_en,
    output logic             busy_en
);
    logic [1:0] line_s;
    bus_evt_t   evt;
    logic       stop_det, start_det;

    twb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({scl_in, sda_in}),
        .q_out (line_s)
    );

    twb_cond_detect u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (line_s[1]),
        .sda_s (line_s[0]),
        .evt   (evt)
    );

    twb_cond_flags u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .if_en         (if_en),
        .wr_en         (wr_en),
        .stop_cmd      (wr_data[B_STOP_CMD]),
        .start_cmd     (wr_data[B_START_CMD]),
        .ack_trig      (wr_data[B_ACK_TRIG]),
        .ack_en_wr     (wr_data[B_ACK_EN]),
        .busy_en_wr    (wr_data[B_BUSY_EN]),
        .xfer_start    (xfer_start),
        .addr_mismatch (addr_mismatch),
        .evt           (evt),
        .stop_det      (stop_det),
        .start_det     (start_det),
        .ack_pend      (ack_drive),
        .sda_latch     (sda_latch),
        .ack_en        (ack_en),
        .busy_en       (busy_en)
    );

    // Assemble the read value; command bits always read zero.
    always_comb begin
        rd_data               = '0;
        rd_data[B_STOP_DET]   = stop_det;
        rd_data[B_START_DET]  = start_det;
        rd_data[B_ACK_EN]     = ack_en;
        rd_data[B_ACK_DET]    = ack_det_i;
        rd_data[B_BUSY_EN]    = busy_en;
    end

    // R1: no state bit survives a reset cycle.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (rd_data[B_STOP_DET] == 1'b0 && rd_data[B_START_DET] == 1'b0 && !ack_drive && sda_latch));
endmodule

// File: tb/tb_twb_cond_ctrl.sv
module tb_twb_cond_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       if_en = 1'b0, xfer_start = 1'b0, addr_mismatch = 1'b0, ack_det_i = 1'b0;
    logic       scl_in = 1'b1, sda_in = 1'b1;
    logic       sda_latch, ack_drive, ack_en, busy_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state
    bit m_latch = 1'b1, m_stopd, m_startd, m_ack, m_acken, m_busyen;
    bit m_scl = 1'b1, m_sda = 1'b1;

    twb_cond_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .if_en(if_en), .xfer_start(xfer_start), .addr_mismatch(addr_mismatch),
        .ack_det_i(ack_det_i), .scl_in(scl_in), .sda_in(sda_in),
        .sda_latch(sda_latch), .ack_drive(ack_drive), .ack_en(ack_en), .busy_en(busy_en)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] exp_rd();
        return {m_busyen, ack_det_i, m_acken, 1'b0, m_startd, m_stopd, 2'b00};
    endfunction

    task automatic check(string req);
        logic [11:0] act, exp;
        act = {rd_data, sda_latch, ack_drive, ack_en, busy_en};
        exp = {exp_rd(), m_latch, m_ack, m_acken, m_busyen};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: rd/latch/ack/acken/busyen actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_write(logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (if_en) begin
            if (d[0]) m_latch = 1'b1;
            else if (d[1]) m_latch = 1'b0;
            if (d[4]) m_ack = 1'b1;
        end
        m_acken = d[5]; m_busyen = d[7];
    endtask

    task automatic pulse_xfer();
        @(negedge clk); xfer_start = 1'b1;
        @(negedge clk); xfer_start = 1'b0;
        m_stopd = 0; m_startd = 0; m_ack = 0;
    endtask

    task automatic pulse_mm();
        @(negedge clk); addr_mismatch = 1'b1;
        @(negedge clk); addr_mismatch = 1'b0;
        m_stopd = 0;
    endtask

    task automatic set_en(bit v);
        @(negedge clk); if_en = v;
        if (!v) begin m_stopd = 0; m_startd = 0; m_ack = 0; end
        idle(1);
    endtask

    // Move one bus line and let the synchronizer settle.
    task automatic move_line(bit is_scl, bit v);
        @(negedge clk);
        if (is_scl) begin
            if (m_scl && !v) m_ack = 0;
            scl_in = v; m_scl = v;
        end else begin
            if (m_scl && if_en && m_sda && !v) m_startd = 1;
            if (m_scl && if_en && !m_sda && v) begin m_stopd = 1; m_startd = 0; end
            sda_in = v; m_sda = v;
        end
        idle(4);
    endtask

    task automatic bus_start();
        move_line(1, 0); move_line(0, 1); move_line(1, 1); move_line(0, 0);
    endtask

    task automatic bus_stop();
        move_line(1, 0); move_line(0, 0); move_line(1, 1); move_line(0, 1);
    endtask

    // R9: SDA move with a clear pulse landing on the third rising edge.
    task automatic race_sda(bit v, bit use_mm);
        @(negedge clk); sda_in = v; m_sda = v;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        if (use_mm) addr_mismatch = 1'b1; else xfer_start = 1'b1;
        @(negedge clk);
        addr_mismatch = 1'b0; xfer_start = 1'b0;
        if (use_mm) begin m_stopd = 0; if (v) m_startd = 0; else m_startd = 1; end
        else begin m_stopd = 0; m_startd = 0; m_ack = 0; end
        idle(3);
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        idle(3);
        check("R1 reset");
        @(negedge clk); rst_n = 1'b1;
        idle(2);
        check("R1 after reset");

        // R4: commands ignored while disabled
        do_write(8'h12); idle(1); check("R4 disabled start/ack cmd");

        set_en(1);
        do_write(8'h02); check("R3 start cmd latch low");
        do_write(8'h01); check("R2 stop cmd latch high");
        do_write(8'h02); do_write(8'h03); check("R3 both cmds -> latch high");
        do_write(8'hFF); check("R11 rw bits, ro bits ignored");
        do_write(8'h00); check("R11 rw bits cleared");

        // R5 latency: flag visible after exactly three rising edges
        move_line(1, 0); move_line(0, 1); move_line(1, 1);
        @(negedge clk); sda_in = 1'b0; m_sda = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        checks++;
        if (rd_data[3] !== 1'b0) begin failures++; $display("FAIL R5 early flag actual=%b expected=0", rd_data[3]); end
        @(negedge clk); m_startd = 1;
        check("R5 start flag at third edge");
        idle(5); check("R5 start sticky");

        move_line(0, 1); check("R6 stop sets, R8 stop clears start");
        pulse_mm(); check("R7 mismatch clears stop");
        bus_start(); pulse_mm(); check("R8 mismatch keeps start");
        pulse_xfer(); check("R8 xfer clears start");
        bus_stop(); set_en(0); set_en(1); check("R7 disable clears stop");

        do_write(8'h10); check("R10 ack drive raised");
        move_line(1, 0); check("R10 ack released on SCL fall");
        do_write(8'h10); pulse_xfer(); check("R10 xfer clears ack");
        do_write(8'h10); set_en(0); check("R10 disable clears ack");
        do_write(8'h10); check("R4 ack write ignored when disabled");
        set_en(1);

        // R9 clear-wins races
        move_line(1, 0); move_line(0, 0); move_line(1, 1);
        bus_start();
        race_sda(1, 1'b0); check("R9 xfer vs stop set");
        move_line(1, 0); move_line(0, 0); move_line(1, 1);
        race_sda(1, 1'b1); check("R9 mismatch vs stop set");
        move_line(1, 0); move_line(0, 1); move_line(1, 1);
        race_sda(0, 1'b0); check("R9 xfer vs start set");

        ack_det_i = 1'b1; idle(1); check("R11 ack detect mirror");
        ack_det_i = 1'b0;

        // Constrained random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 10);
            case (op)
                0, 1: move_line(1, bit'($urandom % 2));
                2, 3: move_line(0, bit'($urandom % 2));
                4: do_write(8'($urandom) & 8'hB3 | ((($urandom % 4) == 0) ? 8'h10 : 8'h00));
                5: pulse_xfer();
                6: pulse_mm();
                7: set_en(($urandom % 5) != 0);
                8: begin ack_det_i = bit'($urandom % 2); idle(1); end
                default: if (!if_en) set_en(1); else bus_start();
            endcase
            check("R5/R6/R7/R8/R10 random mix");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule